// File: doc/BRIEF.md
# Zoned General Register File

This block is a 256-entry, 64-bit general register file. Two threshold values split the register numbers into three zones. The lower bound `lo` marks the top of the low zone, and the upper bound `hi` marks the start of the high zone. Numbers below `lo` are the low zone. Numbers from `hi` to 255 are the high zone. Numbers from `lo` up to `hi - 1` form the gap zone. Stored contents are visible only in the low and high zones. Any gap register reads as zero.

Writing to a gap register stores the data and pulls the lower bound up to that register number plus one. The registers between the old bound and the written one are wiped to zero as part of the same update, so they keep reading as zero after they join the low zone. Both bounds can be loaded directly. The block clamps those loads so that the lower bound never exceeds the upper bound and the upper bound never exceeds 256.

There are two combinational read ports and one write port. Each read port shows the state the register file will hold after the current clock edge: same-cycle write data, same-cycle wipes and same-cycle bound changes all apply to it.

Top module: `zoned_regfile`

## Requirements
- R1: After reset the lower bound is 0, the upper bound is the parameter `HI_RESET` (default 128), and every register reads as zero.
- R2: A register number below the lower bound reads back its stored contents.
- R3: A register number at or above the upper bound reads back its stored contents.
- R4: A register number that is at or above the lower bound and below the upper bound reads as zero, whatever it stores.
- R5: A write to a gap-zone register stores its data and, when neither bound is loaded in that cycle, sets the lower bound to the register number plus one.
- R6: A gap-zone write clears every register numbered from the old lower bound up to one below the written register.
- R7: Loading the upper bound with a value above 256 sets it to 256. After any update the lower bound is at most the upper bound, and a larger value is cut down to the upper bound. This holds when the lower bound is loaded and also when the upper bound is lowered beneath it.
- R8: When the lower bound is loaded in the same cycle as a gap-zone write, the loaded value (after clamping) wins over the automatic raise. The write data and the clearing still take effect.
- R9: A read port returns the value its register will read after the current edge. It includes same-cycle write data, same-cycle clearing and zone membership under the new bounds.
- R10: A write to a low-zone or high-zone register does not change the lower bound.
- R11: The upper bound changes only when it is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd0_num | input | 8 | Register number for read port 0 |
| rd0_data | output | 64 | Read port 0 data (post-update view) |
| rd1_num | input | 8 | Register number for read port 1 |
| rd1_data | output | 64 | Read port 1 data (post-update view) |
| wr_en | input | 1 | Write enable |
| wr_num | input | 8 | Register number written |
| wr_data | input | 64 | Write data |
| lo_load | input | 1 | Load the lower bound this cycle |
| lo_value | input | 9 | Lower bound load value |
| hi_load | input | 1 | Load the upper bound this cycle |
| hi_value | input | 9 | Upper bound load value |
| lo_bound | output | 9 | Current lower bound |
| hi_bound | output | 9 | Current upper bound |

## Verification
The bench fills registers that later fall into the gap and then checks that they read as zero. A design that did not mask the gap would return the stale data. It then performs a gap write and raises the bound by a load, so the wiped range and the surviving stale range both become visible. A design that skipped the wipe, or wiped one register too many or too few, shows wrong data at the edges of the range. Same-cycle reads of the written register, of a wiped register, and of a register made gap by a concurrent bound load catch a read path that uses the old bounds or the stored array. Clamp loads, including lowering the upper bound under the lower one, catch bounds left out of order. A long pseudo-random mix of all operations is then compared against an arithmetic model.

// File: rtl/zoned_regfile_pkg.sv
package zoned_regfile_pkg;

    typedef enum logic [1:0] {
        ZONE_LOW  = 2'd0,
        ZONE_GAP  = 2'd1,
        ZONE_HIGH = 2'd2
    } zone_e;

    // Classify a register number against a lower and an upper bound.
    function automatic zone_e zone_of(input int unsigned num,
                                      input int unsigned lo,
                                      input int unsigned hi);
        if (num < lo)      return ZONE_LOW;
        else if (num < hi) return ZONE_GAP;
        else               return ZONE_HIGH;
    endfunction

endpackage

// File: rtl/zoned_regfile_bounds.sv
module zoned_regfile_bounds
    import zoned_regfile_pkg::*;
#(
    parameter int NUM_REGS = 256,
    parameter int ADDR_W   = 8,
    parameter int THR_W    = 9,
    parameter int HI_RESET = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_num,
    input  logic              lo_load,
    input  logic [THR_W-1:0]  lo_value,
    input  logic              hi_load,
    input  logic [THR_W-1:0]  hi_value,
    output logic [THR_W-1:0]  lo_q,
    output logic [THR_W-1:0]  hi_q,
    output logic [THR_W-1:0]  lo_d,
    output logic [THR_W-1:0]  hi_d,
    output logic              widen
);

    localparam logic [THR_W-1:0] HI_MAX  = THR_W'(NUM_REGS);
    localparam logic [THR_W-1:0] HI_INIT = THR_W'(HI_RESET);

    typedef struct packed {
        logic [THR_W-1:0] lo;
        logic [THR_W-1:0] hi;
    } bounds_t;

    bounds_t          st_q, st_d;
    logic [THR_W-1:0] lo_cand, hi_cand;
    logic             gap_hit;

    always_comb begin
        gap_hit = wr_en &&
                  (zone_of(32'(wr_num), 32'(st_q.lo), 32'(st_q.hi)) == ZONE_GAP);

        if (hi_load) hi_cand = (hi_value > HI_MAX) ? HI_MAX : hi_value;
        else         hi_cand = st_q.hi;

        if (lo_load)      lo_cand = lo_value;
        else if (gap_hit) lo_cand = THR_W'(wr_num) + THR_W'(1);
        else              lo_cand = st_q.lo;

        st_d.hi = hi_cand;
        st_d.lo = (lo_cand > hi_cand) ? hi_cand : lo_cand;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lo <= '0;
            st_q.hi <= HI_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign lo_q  = st_q.lo;
    assign hi_q  = st_q.hi;
    assign lo_d  = st_d.lo;
    assign hi_d  = st_d.hi;
    assign widen = gap_hit;

endmodule

// File: rtl/zoned_regfile_store.sv
module zoned_regfile_store #(
    parameter int NUM_REGS = 256,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 64,
    parameter int THR_W    = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_num,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              widen,
    input  logic [THR_W-1:0]  lo_q,
    output logic [DATA_W-1:0] cells [NUM_REGS]
);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_cell
        logic [DATA_W-1:0] cell_q, cell_d;
        logic              hit, wipe;

        always_comb begin
            hit    = wr_en && (wr_num == ADDR_W'(i));
            wipe   = widen && (THR_W'(i) >= lo_q) && (ADDR_W'(i) < wr_num);
            cell_d = cell_q;
            if (hit)       cell_d = wr_data;
            else if (wipe) cell_d = '0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cell_q <= '0;
            else        cell_q <= cell_d;
        end

        assign cells[i] = cell_q;
    end

endmodule

// File: rtl/zoned_regfile_rdport.sv
module zoned_regfile_rdport
    import zoned_regfile_pkg::*;
#(
    parameter int NUM_REGS = 256,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 64,
    parameter int THR_W    = 9
) (
    input  logic [ADDR_W-1:0] rd_num,
    input  logic [DATA_W-1:0] cells [NUM_REGS],
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_num,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              widen,
    input  logic [THR_W-1:0]  lo_q,
    input  logic [THR_W-1:0]  lo_d,
    input  logic [THR_W-1:0]  hi_d,
    output logic [DATA_W-1:0] rd_data
);

    zone_e zone;
    logic  same_wr, in_wipe;

    always_comb begin
        zone    = zone_of(32'(rd_num), 32'(lo_d), 32'(hi_d));
        same_wr = wr_en && (wr_num == rd_num);
        in_wipe = widen && (THR_W'(rd_num) >= lo_q) && (rd_num < wr_num);

        if (zone == ZONE_GAP) rd_data = '0;
        else if (same_wr)     rd_data = wr_data;
        else if (in_wipe)     rd_data = '0;
        else                  rd_data = cells[rd_num];
    end

endmodule

// File: rtl/zoned_regfile.sv
module zoned_regfile #(
    parameter int NUM_REGS = 256,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 64,
    parameter int HI_RESET = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd0_num,
    output logic [DATA_W-1:0] rd0_data,
    input  logic [ADDR_W-1:0] rd1_num,
    output logic [DATA_W-1:0] rd1_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_num,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              lo_load,
    input  logic [ADDR_W:0]   lo_value,
    input  logic              hi_load,
    input  logic [ADDR_W:0]   hi_value,
    output logic [ADDR_W:0]   lo_bound,
    output logic [ADDR_W:0]   hi_bound
);

    localparam int THR_W  = ADDR_W + 1;
    localparam int NUM_RD = 2;

    logic [THR_W-1:0]  lo_q, hi_q, lo_d, hi_d;
    logic              widen;
    logic [DATA_W-1:0] cells [NUM_REGS];
    logic [ADDR_W-1:0] rd_num_v  [NUM_RD];
    logic [DATA_W-1:0] rd_data_v [NUM_RD];

    zoned_regfile_bounds #(
        .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .THR_W(THR_W), .HI_RESET(HI_RESET)
    ) u_bounds (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_num(wr_num),
        .lo_load(lo_load), .lo_value(lo_value),
        .hi_load(hi_load), .hi_value(hi_value),
        .lo_q(lo_q), .hi_q(hi_q), .lo_d(lo_d), .hi_d(hi_d),
        .widen(widen)
    );

    zoned_regfile_store #(
        .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .THR_W(THR_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_num(wr_num), .wr_data(wr_data),
        .widen(widen), .lo_q(lo_q),
        .cells(cells)
    );

    assign rd_num_v[0] = rd0_num;
    assign rd_num_v[1] = rd1_num;

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        zoned_regfile_rdport #(
            .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .THR_W(THR_W)
        ) u_rd (
            .rd_num(rd_num_v[p]), .cells(cells),
            .wr_en(wr_en), .wr_num(wr_num), .wr_data(wr_data),
            .widen(widen), .lo_q(lo_q), .lo_d(lo_d), .hi_d(hi_d),
            .rd_data(rd_data_v[p])
        );
    end

    assign rd0_data = rd_data_v[0];
    assign rd1_data = rd_data_v[1];
    assign lo_bound = lo_q;
    assign hi_bound = hi_q;

endmodule

// File: rtl/zoned_regfile_chk.sv
module zoned_regfile_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 64,
    parameter int THR_W  = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] rd0_num,
    input logic [DATA_W-1:0] rd0_data,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_num,
    input logic              lo_load,
    input logic              hi_load,
    input logic [THR_W-1:0]  lo_bound,
    input logic [THR_W-1:0]  hi_bound
);

    logic [THR_W-1:0] wr_ext, rd_ext;
    assign wr_ext = THR_W'(wr_num);
    assign rd_ext = THR_W'(rd0_num);

    p_bound_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lo_bound <= hi_bound);

    p_auto_raise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ext >= lo_bound && wr_ext < hi_bound && !lo_load && !hi_load)
        |=> (lo_bound == $past(wr_ext) + THR_W'(1)));

    p_hi_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_load |=> $stable(hi_bound));

    p_lo_no_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!lo_load && !hi_load) |=> (lo_bound >= $past(lo_bound)));

    p_gap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(rd_ext) < lo_bound) || ($past(rd_ext) >= hi_bound) ||
                  ($past(rd0_data) == '0)));

endmodule

bind zoned_regfile zoned_regfile_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .THR_W(THR_W)
) u_chk (.*);

// File: tb/zoned_regfile_bench.sv
module zoned_regfile_bench;

    localparam int N = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rd0_num = '0, rd1_num = '0, wr_num = '0;
    logic [63:0] rd0_data, rd1_data, wr_data = '0;
    logic        wr_en = 1'b0, lo_load = 1'b0, hi_load = 1'b0;
    logic [8:0]  lo_value = '0, hi_value = '0, lo_bound, hi_bound;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    logic [63:0] m_mem [N];
    logic [63:0] n_mem [N];
    int          m_lo, m_hi, n_lo, n_hi;
    int unsigned seed = 32'h1234_5678;

    always #4 clk = ~clk;

    zoned_regfile u_zoned_regfile (
        .clk(clk), .rst_n(rst_n),
        .rd0_num(rd0_num), .rd0_data(rd0_data),
        .rd1_num(rd1_num), .rd1_data(rd1_data),
        .wr_en(wr_en), .wr_num(wr_num), .wr_data(wr_data),
        .lo_load(lo_load), .lo_value(lo_value),
        .hi_load(hi_load), .hi_value(hi_value),
        .lo_bound(lo_bound), .hi_bound(hi_bound)
    );

    function automatic logic [63:0] pat(input int i);
        return (64'h9E37_79B9_7F4A_7C15 * 64'(i + 1)) ^ 64'(i);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: drive, check post-update view, commit model at the edge.
    task automatic cyc(input string tag, input bit we, input int wn, input logic [63:0] wd,
                       input bit ll, input int lv, input bit hl, input int hv,
                       input int r0, input int r1);
        bit gap;
        wr_en = we; wr_num = 8'(wn); wr_data = wd;
        lo_load = ll; lo_value = 9'(lv); hi_load = hl; hi_value = 9'(hv);
        rd0_num = 8'(r0); rd1_num = 8'(r1);
        #1;
        chk({tag, " lo_bound"}, 64'(lo_bound), 64'(m_lo));
        chk({tag, " hi_bound"}, 64'(hi_bound), 64'(m_hi));
        gap  = we && (wn >= m_lo) && (wn < m_hi);
        n_hi = hl ? ((hv > N) ? N : hv) : m_hi;
        n_lo = ll ? lv : (gap ? wn + 1 : m_lo);
        if (n_lo > n_hi) n_lo = n_hi;
        for (int i = 0; i < N; i++) n_mem[i] = m_mem[i];
        if (gap) for (int i = m_lo; i < wn; i++) n_mem[i] = '0;
        if (we) n_mem[wn] = wd;
        chk({tag, " rd0"}, rd0_data, (r0 >= n_lo && r0 < n_hi) ? 64'd0 : n_mem[r0]);
        chk({tag, " rd1"}, rd1_data, (r1 >= n_lo && r1 < n_hi) ? 64'd0 : n_mem[r1]);
        @(posedge clk);
        for (int i = 0; i < N; i++) m_mem[i] = n_mem[i];
        m_lo = n_lo; m_hi = n_hi;
        @(negedge clk);
    endtask

    task automatic idle_read(input string tag, input int r0, input int r1);
        cyc(tag, 0, 0, '0, 0, 0, 0, 0, r0, r1);
    endtask

    function automatic string zone_tag(input int r);
        if (r < m_lo)      return "R2";
        else if (r < m_hi) return "R4";
        else               return "R3";
    endfunction

    function automatic int unsigned rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed >> 8;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) m_mem[i] = '0;
        m_lo = 0; m_hi = 128;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, every register reads zero
        for (int i = 0; i < N; i++) idle_read("R1", i, N - 1 - i);

        // R7: load both bounds
        cyc("R7", 0, 0, '0, 1, 100, 1, 200, 0, 0);

        // R10: fill low and high zones, read the written register same cycle (R9)
        for (int i = 0; i < 100; i++) cyc("R10", 1, i, pat(i), 0, 0, 0, 0, i, (i * 37) % N);
        for (int i = 200; i < N; i++) cyc("R10", 1, i, pat(i), 0, 0, 0, 0, i, (i * 37) % N);

        // R2 / R3 / R4 sweep
        for (int i = 0; i < N; i++) idle_read(zone_tag(i), i, N - 1 - i);

        // Stale data in the future gap: widen the low zone, fill, shrink again
        cyc("R7", 0, 0, '0, 1, 200, 0, 0, 150, 120);
        for (int i = 100; i < 200; i++) cyc("R10", 1, i, pat(i + 7), 0, 0, 0, 0, i, 300 - i);
        cyc("R7", 0, 0, '0, 1, 100, 0, 0, 150, 120);
        for (int i = 100; i < 200; i++) idle_read("R4", i, i - 50);

        // R5: gap write raises the bound; same-cycle reads of target and wiped reg (R9)
        cyc("R5", 1, 150, 64'hDEAD_BEEF_0BAD_F00D, 0, 0, 0, 0, 150, 120);
        idle_read("R5", 150, 151);

        // R6: expose wiped and surviving ranges
        cyc("R7", 0, 0, '0, 1, 200, 0, 0, 99, 100);
        for (int i = 95; i < 205; i++) idle_read("R6", i, 304 - i);

        // R9: same-cycle write/read in high zone and gap write with wipe read
        cyc("R9", 1, 230, 64'h1111_2222_3333_4444, 0, 0, 0, 0, 230, 231);
        cyc("R9", 0, 0, '0, 1, 10, 0, 0, 30, 60);
        cyc("R9", 1, 60, 64'h5555_6666_7777_8888, 0, 0, 0, 0, 30, 60);
        cyc("R9", 0, 0, '0, 0, 0, 1, 40, 45, 20);

        // R8: lower-bound load beats automatic raise
        cyc("R7", 0, 0, '0, 1, 61, 1, 200, 61, 99);
        cyc("R8", 1, 100, 64'hCAFE_F00D_1234_5678, 1, 70, 0, 0, 100, 65);
        idle_read("R8", 100, 80);
        cyc("R7", 0, 0, '0, 1, 200, 0, 0, 100, 80);
        for (int i = 55; i < 105; i++) idle_read("R8", i, i + 100);

        // R7 clamps
        cyc("R7", 0, 0, '0, 1, 250, 0, 0, 0, 255);
        cyc("R7", 0, 0, '0, 0, 0, 1, 300, 255, 199);
        cyc("R7", 0, 0, '0, 0, 0, 1, 50, 49, 50);
        cyc("R7", 0, 0, '0, 1, 500, 1, 511, 255, 128);
        cyc("R7", 0, 0, '0, 1, 20, 1, 50, 49, 50);
        for (int i = 0; i < N; i++) idle_read("R7", i, (i * 5) % N);

        // R11: pseudo-random mix of all operations
        for (int k = 0; k < 3000; k++) begin
            int unsigned a = rnd();
            int unsigned b = rnd();
            bit ll = (a % 13) == 0;
            bit hl = (b % 17) == 0;
            cyc("R11", (a % 3) != 0, int'(b % N), {rnd(), rnd()} ,
                ll, int'(a % 300), hl, int'((b >> 4) % 300),
                int'(rnd() % N), int'(rnd() % N));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule